// File: doc/BRIEF.md
# USB OUT Endpoint Packet Buffer Controller

This block serves one USB device OUT endpoint. It sits between a packet-level receive engine, which delivers a start strobe with the data PID, then the payload bytes, then an end strobe with a CRC/bit-stuff error flag, and a CPU that sees one 8-bit control/status register and a byte-wide read port into the packet store. Received packets go into a packet-granular store that holds one packet, or two when double buffering is enabled.

For each packet the controller decides whether to keep it and which handshake the receive engine returns (ACK, NAK or STALL, or none). It also keeps the expected DATA0/DATA1 toggle. Software releases a packet by clearing the packet-ready bit. It can also discard the next packet with a self-clearing flush, force STALL responses, and reset the toggle. In isochronous mode no handshake is given. A packet lost to a full store raises a sticky overrun flag, and a stored packet that arrived with an error is marked with a data-error flag.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, no handshake is presented and the interrupt is low.
- R2: A stored packet sets packet-ready (bit 0) and pulses `irq_o` one cycle after the end strobe's commit. `pkt_len_o` gives its byte count, and its bytes come out of `fifo_rdata_o` in arrival order, one per `fifo_rd_i` pulse. Writing the status byte with bit 0 = 0 while packet-ready is set releases the packet.
- R3: Full (bit 1, read-only) is set when one packet is held with double buffering off, and when two are held with double buffering on.
- R4: Outside isochronous mode, a packet that starts while the store is full gets NAK and is not stored.
- R5: The toggle expects DATA0 after reset. A stored ACKed packet flips it. A packet with the other PID gets ACK but is discarded, and the toggle is left as it was.
- R6: Writing 1 to bit 7 resets the expected toggle to DATA0. Bit 7 always reads 0.
- R7: While send-stall (bit 5) is 1 outside isochronous mode, packets get STALL and are not stored. Each STALL sets stall-sent (bit 6). Bit 6 is cleared only by writing it as 0; writing 1 leaves it set.
- R8: Send-stall has no effect in isochronous mode: packets are stored with no handshake.
- R9: Outside isochronous mode, a packet with a CRC or bit-stuff error gets no handshake, is dropped, and leaves the toggle unchanged.
- R10: In isochronous mode no handshake is ever given. An errored packet is still stored, and data-error (bit 3) reads 1 while that packet is ready. It clears when packet-ready is cleared.
- R11: In isochronous mode, a packet arriving while the store is full sets overrun (bit 2) and is not stored. Overrun stays set until bit 2 is written as 0; writing 1 leaves it set.
- R12: Writing 1 to flush (bit 4) discards the next packet and clears packet-ready. Bit 4 reads 1 for exactly one cycle and then returns to 0 by itself.
- R13: With double buffering, releasing the first packet clears packet-ready. Packet-ready re-asserts on the following cycle, with an interrupt, when a second packet is held, and the read port then delivers that packet's bytes.

Handshake codes on `hs_code_o` are 1 = ACK, 2 = NAK, 3 = STALL. They are valid in the cycle after `rx_end_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iso_mode_i | input | 1 | Isochronous mode |
| dbl_buf_i | input | 1 | Double buffering enable |
| rx_start_i | input | 1 | Start of a data packet |
| rx_data1_i | input | 1 | PID of the starting packet is DATA1 |
| rx_valid_i | input | 1 | Payload byte valid |
| rx_data_i | input | 8 | Payload byte |
| rx_end_i | input | 1 | End of packet strobe |
| rx_err_i | input | 1 | CRC or bit-stuff error, valid with rx_end_i |
| hs_valid_o | output | 1 | Handshake to send |
| hs_code_o | output | 2 | Handshake code |
| csr_wr_i | input | 1 | Status byte write strobe |
| csr_wdata_i | input | 8 | Status byte write data |
| csr_rdata_o | output | 8 | Status byte read value |
| fifo_rd_i | input | 1 | Advance read pointer by one byte |
| fifo_rdata_o | output | 8 | Current byte of the ready packet |
| pkt_len_o | output | LEN_W | Byte count of the ready packet |
| irq_o | output | 1 | One-cycle pulse when packet-ready sets |

## Verification
The bench builds the block with SLOT_BYTES = 4, so every payload length from empty to a full slot can be swept. Each swept packet's bytes are computed from its base value and index. The small slot also lets a few packets fill both buffers. This brings every full-store outcome within reach: NAK, overrun, and the double-buffer hand-over from one packet to the next. The toggle is tracked arithmetically in the bench across stored, duplicate, stalled, errored and flushed packets.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;

  typedef enum logic [1:0] {
    WHY_STORE = 2'd0,
    WHY_DUP   = 2'd1,
    WHY_FULL  = 2'd2,
    WHY_STALL = 2'd3
  } why_e;

  localparam int unsigned B_RDY    = 0;
  localparam int unsigned B_FULL   = 1;
  localparam int unsigned B_OVR    = 2;
  localparam int unsigned B_DERR   = 3;
  localparam int unsigned B_FLUSH  = 4;
  localparam int unsigned B_SSTALL = 5;
  localparam int unsigned B_STSENT = 6;
  localparam int unsigned B_CLRTOG = 7;
endpackage

// File: rtl/ep_pkt_buf.sv
module ep_pkt_buf #(
  parameter int unsigned SLOT_BYTES = 64,
  localparam int unsigned LEN_W = $clog2(SLOT_BYTES + 1),
  localparam int unsigned PTR_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_buf_i,
  input  logic             wr_open_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             commit_i,
  input  logic             commit_err_i,
  input  logic             pop_i,
  input  logic             rd_adv_i,
  output logic             full_o,
  output logic             nonempty_o,
  output logic [7:0]       rd_data_o,
  output logic [LEN_W-1:0] rd_len_o,
  output logic             rd_err_o
);
  localparam int unsigned NSLOT = 2;

  logic [7:0]       mem_q [NSLOT][SLOT_BYTES];
  logic [LEN_W-1:0] slot_len_q [NSLOT];
  logic             slot_err_q [NSLOT];
  logic [1:0]       count_q;
  logic             wr_slot_q, rd_slot_q;
  logic [LEN_W-1:0] wr_len_q, rd_ptr_q;
  logic             wr_room;

  assign wr_room    = wr_len_q < LEN_W'(SLOT_BYTES);
  assign full_o     = count_q >= (dbl_buf_i ? 2'd2 : 2'd1);
  assign nonempty_o = count_q != 2'd0;
  assign rd_data_o  = mem_q[rd_slot_q][rd_ptr_q[PTR_W-1:0]];
  assign rd_len_o   = slot_len_q[rd_slot_q];
  assign rd_err_o   = slot_err_q[rd_slot_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_room) mem_q[wr_slot_q][wr_len_q[PTR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_len_q <= '0;
    end else if (wr_open_i) begin
      wr_len_q <= '0;
    end else if (wr_en_i && wr_room) begin
      wr_len_q <= wr_len_q + 1'b1;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_len_q[s] <= '0;
        slot_err_q[s] <= 1'b0;
      end else if (commit_i && (wr_slot_q == 1'(s))) begin
        slot_len_q[s] <= wr_len_q;
        slot_err_q[s] <= commit_err_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      wr_slot_q <= 1'b0;
      rd_slot_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      count_q <= count_q + {1'b0, commit_i} - {1'b0, pop_i};
      if (commit_i) wr_slot_q <= ~wr_slot_q;
      if (pop_i) begin
        rd_slot_q <= ~rd_slot_q;
        rd_ptr_q  <= '0;
      end else if (rd_adv_i && (rd_ptr_q < rd_len_o)) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end

  p_commit_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !full_o);
  p_pop_nonempty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/ep_rx_judge.sv
module ep_rx_judge
  import usb_out_ep_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     iso_i,
  input  logic     stall_req_i,
  input  logic     full_i,
  input  logic     clr_toggle_i,
  input  logic     rx_start_i,
  input  logic     rx_data1_i,
  input  logic     rx_valid_i,
  input  logic     rx_end_i,
  input  logic     rx_err_i,
  output logic     wr_open_o,
  output logic     wr_en_o,
  output logic     commit_o,
  output logic     commit_err_o,
  output logic     overrun_o,
  output logic     stall_sent_o,
  output logic     hs_valid_o,
  output hs_code_e hs_code_o
);
  logic     active_q, keep_q, toggle_q, hs_valid_q;
  why_e     why_q, why_d;
  hs_code_e hs_code_q, hs_d;
  logic     end_hit;

  always_comb begin
    if (iso_i)                      why_d = full_i ? WHY_FULL : WHY_STORE;
    else if (stall_req_i)           why_d = WHY_STALL;
    else if (full_i)                why_d = WHY_FULL;
    else if (rx_data1_i != toggle_q) why_d = WHY_DUP;
    else                            why_d = WHY_STORE;
  end

  always_comb begin
    case (why_q)
      WHY_STALL: hs_d = HS_STALL;
      WHY_FULL:  hs_d = HS_NAK;
      default:   hs_d = HS_ACK;
    endcase
  end

  assign end_hit      = rx_end_i && active_q;
  assign wr_open_o    = rx_start_i;
  assign wr_en_o      = rx_valid_i && active_q && keep_q;
  assign commit_o     = end_hit && keep_q && (iso_i || !rx_err_i);
  assign commit_err_o = rx_err_i;
  assign overrun_o    = end_hit && iso_i && (why_q == WHY_FULL);
  assign hs_valid_o   = hs_valid_q;
  assign hs_code_o    = hs_code_q;
  assign stall_sent_o = hs_valid_q && (hs_code_q == HS_STALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      keep_q     <= 1'b0;
      why_q      <= WHY_STORE;
      toggle_q   <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
    end else begin
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
      if (rx_start_i) begin
        active_q <= 1'b1;
        keep_q   <= (why_d == WHY_STORE);
        why_q    <= why_d;
      end else if (rx_end_i) begin
        active_q <= 1'b0;
      end
      if (end_hit && !iso_i && !rx_err_i) begin
        hs_valid_q <= 1'b1;
        hs_code_q  <= hs_d;
      end
      if (clr_toggle_i)             toggle_q <= 1'b0;
      else if (commit_o && !iso_i)  toggle_q <= ~toggle_q;
    end
  end

  p_iso_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_end_i && iso_i) |=> !hs_valid_o);
  p_err_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_end_i && rx_err_i) |=> !hs_valid_o);
  p_clr_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_toggle_i |=> !toggle_q);
endmodule

// File: rtl/ep_csr.sv
module ep_csr
  import usb_out_ep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iso_i,
  input  logic       csr_wr_i,
  input  logic [7:0] csr_wdata_i,
  input  logic       nonempty_i,
  input  logic       full_i,
  input  logic       rd_err_i,
  input  logic       overrun_set_i,
  input  logic       stall_sent_set_i,
  output logic       pop_o,
  output logic       clr_toggle_o,
  output logic       send_stall_o,
  output logic [7:0] csr_rdata_o,
  output logic       irq_o
);
  logic rdy_q, flush_q, ovr_q, stsent_q, sstall_q, irq_q;
  logic release_req, flush_req;

  assign release_req  = csr_wr_i && rdy_q && !csr_wdata_i[B_RDY];
  assign flush_req    = csr_wr_i && csr_wdata_i[B_FLUSH];
  assign pop_o        = (release_req || flush_req) && nonempty_i;
  assign clr_toggle_o = csr_wr_i && csr_wdata_i[B_CLRTOG];
  assign send_stall_o = sstall_q;
  assign irq_o        = irq_q;

  always_comb begin
    csr_rdata_o           = '0;
    csr_rdata_o[B_RDY]    = rdy_q;
    csr_rdata_o[B_FULL]   = full_i;
    csr_rdata_o[B_OVR]    = ovr_q;
    csr_rdata_o[B_DERR]   = rdy_q && rd_err_i && iso_i;
    csr_rdata_o[B_FLUSH]  = flush_q;
    csr_rdata_o[B_SSTALL] = sstall_q;
    csr_rdata_o[B_STSENT] = stsent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q    <= 1'b0;
      flush_q  <= 1'b0;
      ovr_q    <= 1'b0;
      stsent_q <= 1'b0;
      sstall_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      flush_q <= flush_req;
      if (release_req || flush_req) begin
        rdy_q <= 1'b0;
      end else if (!rdy_q && nonempty_i) begin
        rdy_q <= 1'b1;
        irq_q <= 1'b1;
      end
      if (overrun_set_i)                          ovr_q <= 1'b1;
      else if (csr_wr_i && !csr_wdata_i[B_OVR])   ovr_q <= 1'b0;
      if (stall_sent_set_i)                       stsent_q <= 1'b1;
      else if (csr_wr_i && !csr_wdata_i[B_STSENT]) stsent_q <= 1'b0;
      if (csr_wr_i) sstall_q <= csr_wdata_i[B_SSTALL];
    end
  end

  p_flush_selfclr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && !csr_wr_i) |=> !flush_q);
  p_irq_with_rdy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rdy_q);
  p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !csr_wr_i) |=> ovr_q);
  p_stsent_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stsent_q && !csr_wr_i) |=> stsent_q);
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 64,
  localparam int unsigned LEN_W = $clog2(SLOT_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iso_mode_i,
  input  logic             dbl_buf_i,
  input  logic             rx_start_i,
  input  logic             rx_data1_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_end_i,
  input  logic             rx_err_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_code_o,
  input  logic             csr_wr_i,
  input  logic [7:0]       csr_wdata_i,
  output logic [7:0]       csr_rdata_o,
  input  logic             fifo_rd_i,
  output logic [7:0]       fifo_rdata_o,
  output logic [LEN_W-1:0] pkt_len_o,
  output logic             irq_o
);
  logic     wr_open, wr_en, commit, commit_err, overrun_set, stall_sent_set;
  logic     full, nonempty, rd_err, pop, clr_toggle, send_stall;
  hs_code_e hs_code;

  ep_rx_judge u_judge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .iso_i        (iso_mode_i),
    .stall_req_i  (send_stall),
    .full_i       (full),
    .clr_toggle_i (clr_toggle),
    .rx_start_i   (rx_start_i),
    .rx_data1_i   (rx_data1_i),
    .rx_valid_i   (rx_valid_i),
    .rx_end_i     (rx_end_i),
    .rx_err_i     (rx_err_i),
    .wr_open_o    (wr_open),
    .wr_en_o      (wr_en),
    .commit_o     (commit),
    .commit_err_o (commit_err),
    .overrun_o    (overrun_set),
    .stall_sent_o (stall_sent_set),
    .hs_valid_o   (hs_valid_o),
    .hs_code_o    (hs_code)
  );
  assign hs_code_o = hs_code;

  ep_pkt_buf #(.SLOT_BYTES(SLOT_BYTES)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dbl_buf_i    (dbl_buf_i),
    .wr_open_i    (wr_open),
    .wr_en_i      (wr_en),
    .wr_data_i    (rx_data_i),
    .commit_i     (commit),
    .commit_err_i (commit_err),
    .pop_i        (pop),
    .rd_adv_i     (fifo_rd_i),
    .full_o       (full),
    .nonempty_o   (nonempty),
    .rd_data_o    (fifo_rdata_o),
    .rd_len_o     (pkt_len_o),
    .rd_err_o     (rd_err)
  );

  ep_csr u_csr (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .iso_i            (iso_mode_i),
    .csr_wr_i         (csr_wr_i),
    .csr_wdata_i      (csr_wdata_i),
    .nonempty_i       (nonempty),
    .full_i           (full),
    .rd_err_i         (rd_err),
    .overrun_set_i    (overrun_set),
    .stall_sent_set_i (stall_sent_set),
    .pop_o            (pop),
    .clr_toggle_o     (clr_toggle),
    .send_stall_o     (send_stall),
    .csr_rdata_o      (csr_rdata_o),
    .irq_o            (irq_o)
  );
endmodule

// File: tb/tb_usb_out_ep_ctrl.sv
module tb_usb_out_ep_ctrl;
  localparam int unsigned SB = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       iso = 1'b0, dbl = 1'b0;
  logic       rx_start = 1'b0, rx_d1 = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic       csr_wr = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata, fifo_rdata;
  logic       fifo_rd = 1'b0, irq;
  logic [2:0] pkt_len;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  int         tog = 0;

  always #2 clk = ~clk;

  usb_out_ep_ctrl #(.SLOT_BYTES(SB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .iso_mode_i(iso), .dbl_buf_i(dbl),
    .rx_start_i(rx_start), .rx_data1_i(rx_d1), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_end_i(rx_end), .rx_err_i(rx_err),
    .hs_valid_o(hs_valid), .hs_code_o(hs_code), .csr_wr_i(csr_wr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .fifo_rd_i(fifo_rd),
    .fifo_rdata_o(fifo_rdata), .pkt_len_o(pkt_len), .irq_o(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'(base + 7 * i + 1);
  endfunction

  // returns handshake (0 none, 1 ACK, 2 NAK, 3 STALL) and irq seen after commit
  task automatic send(input int pid, input int n, input bit err, input int base,
                      output int hs, output int irq_seen);
    rx_start = 1'b1; rx_d1 = pid[0];
    tick();
    rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = pat(base, i);
      tick();
    end
    rx_valid = 1'b0;
    rx_end = 1'b1; rx_err = err;
    tick();
    hs = hs_valid ? int'(hs_code) : 0;
    rx_end = 1'b0; rx_err = 1'b0;
    tick();
    irq_seen = int'(irq);
  endtask

  task automatic csr_write(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    tick();
    csr_wr = 1'b0;
  endtask

  task automatic read_pkt(input string req, input int base, input int n);
    chk({req, " length"}, int'(pkt_len), n);
    for (int i = 0; i < n; i++) begin
      chk({req, " byte"}, int'(fifo_rdata), int'(pat(base, i)));
      fifo_rd = 1'b1;
      tick();
      fifo_rd = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hs, ir;
    repeat (3) tick();
    // R1 reset state
    chk("R1 csr", int'(csr_rdata), 0);
    chk("R1 hs", int'(hs_valid), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 csr after release", int'(csr_rdata), 0);

    // R2/R3/R5 length sweep, single buffer, alternating toggle
    for (int n = 0; n <= SB; n++) begin
      send(tog, n, 1'b0, 16 * n, hs, ir);
      chk("R5 stored ack", hs, 1);
      chk("R2 irq", ir, 1);
      chk("R2 R3 csr ready+full", int'(csr_rdata), 8'h03);
      read_pkt("R2", 16 * n, n);
      csr_write(8'h00);
      chk("R2 released", int'(csr_rdata), 0);
      tog ^= 1;
    end

    // R5 duplicate: wrong PID is ACKed, dropped
    send(tog ^ 1, 3, 1'b0, 5, hs, ir);
    chk("R5 dup ack", hs, 1);
    chk("R5 dup not stored", int'(csr_rdata), 0);

    // R4 NAK when full
    send(tog, 2, 1'b0, 90, hs, ir);
    tog ^= 1;
    send(tog, 3, 1'b0, 120, hs, ir);
    chk("R4 nak", hs, 2);
    chk("R4 irq quiet", ir, 0);
    chk("R4 csr", int'(csr_rdata), 8'h03);
    read_pkt("R4 held intact", 90, 2);
    csr_write(8'h00);
    tick();
    chk("R4 nothing stored", int'(csr_rdata), 0);

    // R6 clear toggle
    if (tog == 0) begin
      send(0, 1, 1'b0, 3, hs, ir);
      csr_write(8'h00);
      tog = 1;
    end
    csr_write(8'h80);
    chk("R6 bit7 reads 0", int'(csr_rdata), 0);
    send(1, 2, 1'b0, 30, hs, ir);
    chk("R6 data1 now dup", int'(csr_rdata), 0);
    send(0, 2, 1'b0, 31, hs, ir);
    chk("R6 data0 stored", int'(csr_rdata), 8'h03);
    read_pkt("R6", 31, 2);
    csr_write(8'h00);
    tog = 1;

    // R7 stall
    csr_write(8'h20);
    chk("R7 stall bit", int'(csr_rdata), 8'h20);
    send(tog, 2, 1'b0, 50, hs, ir);
    chk("R7 stall hs", hs, 3);
    chk("R7 stall-sent, not stored", int'(csr_rdata), 8'h60);
    csr_write(8'h60);
    chk("R7 write 1 keeps", int'(csr_rdata), 8'h60);
    csr_write(8'h20);
    chk("R7 write 0 clears", int'(csr_rdata), 8'h20);
    csr_write(8'h00);
    send(tog, 2, 1'b0, 51, hs, ir);
    chk("R7 ack after stall", hs, 1);
    read_pkt("R7", 51, 2);
    csr_write(8'h00);
    tog ^= 1;

    // R9 error outside iso
    send(tog, 3, 1'b1, 60, hs, ir);
    chk("R9 no hs", hs, 0);
    chk("R9 dropped", int'(csr_rdata), 0);
    send(tog, 3, 1'b0, 61, hs, ir);
    chk("R9 toggle kept", hs, 1);
    read_pkt("R9", 61, 3);
    csr_write(8'h00);
    tog ^= 1;

    // R13 R3 double buffering
    dbl = 1'b1;
    send(tog, 2, 1'b0, 64, hs, ir);
    tog ^= 1;
    chk("R3 one of two not full", int'(csr_rdata), 8'h01);
    send(tog, 4, 1'b0, 128, hs, ir);
    tog ^= 1;
    chk("R3 two of two full", int'(csr_rdata), 8'h03);
    send(tog, 1, 1'b0, 9, hs, ir);
    chk("R4 nak double", hs, 2);
    read_pkt("R13 first", 64, 2);
    csr_write(8'h00);
    chk("R13 ready drops", int'(csr_rdata), 8'h00);
    tick();
    chk("R13 ready back", int'(csr_rdata), 8'h01);
    chk("R13 irq", int'(irq), 1);
    read_pkt("R13 second", 128, 4);
    csr_write(8'h00);
    chk("R13 empty", int'(csr_rdata), 0);

    // R12 flush
    send(tog, 3, 1'b0, 200, hs, ir);
    tog ^= 1;
    send(tog, 2, 1'b0, 210, hs, ir);
    tog ^= 1;
    csr_write(8'h11);
    chk("R12 flush reads 1", int'(csr_rdata), 8'h10);
    tick();
    chk("R12 flush clears", int'(csr_rdata), 8'h01);
    read_pkt("R12 next packet", 210, 2);
    csr_write(8'h00);
    chk("R12 empty", int'(csr_rdata), 0);

    // R8 R10 R11 isochronous
    dbl = 1'b0; iso = 1'b1;
    csr_write(8'h20);
    send(1, 3, 1'b0, 70, hs, ir);
    chk("R10 iso no hs", hs, 0);
    chk("R8 stall ignored", int'(csr_rdata), 8'h23);
    send(0, 2, 1'b0, 80, hs, ir);
    chk("R10 iso no hs full", hs, 0);
    chk("R11 overrun", int'(csr_rdata), 8'h27);
    read_pkt("R11 held intact", 70, 3);
    csr_write(8'h24);
    chk("R11 sticky on write 1", int'(csr_rdata), 8'h24);
    tick();
    chk("R11 not stored", int'(csr_rdata), 8'h24);
    csr_write(8'h00);
    chk("R11 cleared", int'(csr_rdata), 0);
    send(0, 2, 1'b1, 99, hs, ir);
    chk("R10 err no hs", hs, 0);
    chk("R10 data error", int'(csr_rdata), 8'h0B);
    read_pkt("R10 err pkt", 99, 2);
    csr_write(8'h00);
    chk("R10 derr clears", int'(csr_rdata), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule